// File: doc/BRIEF.md
# Low-Speed Clock Domain Control Register

This block is a 32-bit control and status word for a battery-backed low-speed clock domain. Software reaches it through a simple synchronous port: a write strobe with a data word, and a read word that always shows the current state. The block keeps the enable and ready handshake for three clocks: an external crystal oscillator, an internal low-speed oscillator, and a system clock derived from the external one. The oscillators are not modelled as analog parts. Each one is represented by a single-cycle tick input in the register clock domain, and every ready flag rises or falls after a fixed number of those ticks.

The register guards its own configuration. The external oscillator's bypass, drive and filter settings are frozen while that oscillator is enabled or still ready. The internal oscillator's divider is frozen while that oscillator is enabled, ready, or in use by the watchdog or RTC. The clock-security enable cannot be cleared, and the RTC source select cannot be changed once it is nonzero. A hardware failure event releases both of these locks. A synchronous domain-reset input returns every field to zero, locks included.

Top module: `lsclk_ctrl_reg`

## Requirements
- R1: After rst_n is released, and in the cycle after dom_rst_i is high, the read word is 0. The internal-ready bit (bit 25) is the one exception and follows int_in_use_i. dom_rst_i takes priority over a write in the same cycle.
- R2: After the external enable (bit 0) is cleared, the external ready flag (bit 1) stays 1 through five ext_tick_i pulses and reads 0 after the sixth.
- R3: After the internal enable (bit 24) is cleared, the internal ready flag (bit 25) stays 1 through two int_tick_i pulses and reads 0 after the third.
- R4: While int_in_use_i is 1, bit 25 reads 1 whatever the internal enable is.
- R5: A write to bypass (bit 2), drive (bits 4:3) or glitch filter (bit 12) takes effect only if bit 0 and bit 1 are both 0 before the write. Otherwise those bits keep their value.
- R6: The system-clock ready flag (bit 11) rises on the second ext_tick_i after system-clock enable (bit 7) is set while bits 0 and 1 are both 1. It reads 0 from the cycle after bit 0 or bit 1 goes low.
- R7: Once the security enable (bit 5) is 1, a write of 0 to it is ignored unless the failure flag (bit 6) is 1.
- R8: The failure flag (bit 6) is set by a pulse on fail_i and only by that input. Software writes never change bits 1, 6, 11 or 25.
- R9: Once the RTC select (bits 9:8) holds a nonzero value, writes to it are ignored until dom_rst_i or until bit 6 is 1.
- R10: A write to the divider (bit 26) takes effect only if bit 24 is 0, bit 25 is 0 and int_in_use_i is 0.
- R11: The external ready flag rises on the fourth ext_tick_i after bit 0 is set. The internal ready flag rises on the second int_tick_i after bit 24 is set.
- R12: Each tick count restarts when its enable toggles. An enable that is cleared and set again before ready rises needs the full four ticks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_rst_i | input | 1 | Synchronous domain reset, clears every field |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data word |
| rd_data_o | output | 32 | Current register contents |
| ext_tick_i | input | 1 | One-cycle pulse per external low-speed clock period |
| int_tick_i | input | 1 | One-cycle pulse per internal low-speed clock period |
| int_in_use_i | input | 1 | Watchdog or RTC is using the internal oscillator |
| fail_i | input | 1 | Failure event from the external clock monitor |

## Verification
The assertions check on every cycle that the held fields do not move while they are locked:
- the external configuration bits,
- the divider,
- the RTC select,
- the security enable.

They also check that the system-clock ready flag falls as soon as the external clock stops being enabled and ready, that a ready flag with its enable set only rises on a tick, that the failure flag only rises after a failure pulse, and that a domain reset leaves the word empty. The exact tick counts can only be shown by the bench's scenarios, which step one tick at a time and look at the flag on each side of the edge. These counts are:
- four external ticks and two internal ticks to become ready,
- six external ticks and three internal ticks to drop,
- the count restarting when an enable toggles.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
  localparam int DW        = 32;
  localparam int B_XEN     = 0;
  localparam int B_XRDY    = 1;
  localparam int B_XBYP    = 2;
  localparam int B_XDRV_LO = 3;
  localparam int B_XDRV_HI = 4;
  localparam int B_SECEN   = 5;
  localparam int B_FAIL    = 6;
  localparam int B_SYSEN   = 7;
  localparam int B_RTC_LO  = 8;
  localparam int B_RTC_HI  = 9;
  localparam int B_SYSRDY  = 11;
  localparam int B_XFILT   = 12;
  localparam int B_IEN     = 24;
  localparam int B_IRDY    = 25;
  localparam int B_IDIV    = 26;
  localparam int DRV_W     = B_XDRV_HI - B_XDRV_LO + 1;
  localparam int RTC_W     = B_RTC_HI - B_RTC_LO + 1;
endpackage

// File: rtl/lsclk_rdy_track.sv
module lsclk_rdy_track #(
  parameter int ON_TICKS  = 4,
  parameter int OFF_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  input  logic hold_i,
  output logic rdy_o
);
  localparam int MAXL = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int CW   = $clog2(MAXL + 1);
  localparam int OFFL = (OFF_TICKS > 0) ? OFF_TICKS : 1;

  logic          en_d_q, en_d_n;
  logic          rdy_q, rdy_n;
  logic [CW-1:0] cnt_q, cnt_n, base;

  always_comb begin
    base   = (en_i != en_d_q) ? '0 : cnt_q;
    cnt_n  = base;
    rdy_n  = rdy_q;
    en_d_n = en_i;
    if (clr_i) begin
      cnt_n  = '0;
      rdy_n  = 1'b0;
      en_d_n = 1'b0;
    end else if (en_i && !rdy_q) begin
      if (tick_i) begin
        if (base == CW'(ON_TICKS - 1)) begin
          rdy_n = 1'b1;
          cnt_n = '0;
        end else begin
          cnt_n = base + 1'b1;
        end
      end
    end else if (!en_i && rdy_q) begin
      if (OFF_TICKS == 0) begin
        rdy_n = 1'b0;
        cnt_n = '0;
      end else if (tick_i) begin
        if (base == CW'(OFFL - 1)) begin
          rdy_n = 1'b0;
          cnt_n = '0;
        end else begin
          cnt_n = base + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q <= 1'b0;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_d_q <= en_d_n;
      rdy_q  <= rdy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign rdy_o = rdy_q | hold_i;

  // R11: with the enable held, ready only rises on a tick
  a_r11_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i && !clr_i) |=> $stable(rdy_q));
endmodule

// File: rtl/lsclk_ctrl_reg.sv
module lsclk_ctrl_reg
  import lsclk_pkg::*;
#(
  parameter int XON_TICKS   = 4,
  parameter int XOFF_TICKS  = 6,
  parameter int ION_TICKS   = 2,
  parameter int IOFF_TICKS  = 3,
  parameter int SYSON_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dom_rst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          ext_tick_i,
  input  logic          int_tick_i,
  input  logic          int_in_use_i,
  input  logic          fail_i
);
  logic             xen_q, xen_n, xbyp_q, xbyp_n, xfilt_q, xfilt_n;
  logic [DRV_W-1:0] xdrv_q, xdrv_n;
  logic             secen_q, secen_n, fail_q, fail_n, sysen_q, sysen_n;
  logic [RTC_W-1:0] rtc_q, rtc_n;
  logic             ien_q, ien_n, idiv_q, idiv_n;
  logic             xrdy, irdy, sysrdy;
  logic             xcfg_open, idiv_open, rtc_open, sec_clr_ok;

  assign xcfg_open  = !xen_q && !xrdy;
  assign idiv_open  = !ien_q && !irdy && !int_in_use_i;
  assign rtc_open   = (rtc_q == '0) || fail_q;
  assign sec_clr_ok = fail_q;

  always_comb begin
    xen_n = xen_q;  xbyp_n = xbyp_q;  xfilt_n = xfilt_q;  xdrv_n = xdrv_q;
    secen_n = secen_q;  sysen_n = sysen_q;  rtc_n = rtc_q;
    ien_n = ien_q;  idiv_n = idiv_q;
    fail_n = fail_q | fail_i;
    if (dom_rst_i) begin
      xen_n = 1'b0;  xbyp_n = 1'b0;  xfilt_n = 1'b0;  xdrv_n = '0;
      secen_n = 1'b0;  sysen_n = 1'b0;  rtc_n = '0;
      ien_n = 1'b0;  idiv_n = 1'b0;  fail_n = 1'b0;
    end else if (wr_en_i) begin
      xen_n   = wr_data_i[B_XEN];
      sysen_n = wr_data_i[B_SYSEN];
      ien_n   = wr_data_i[B_IEN];
      if (xcfg_open) begin
        xbyp_n  = wr_data_i[B_XBYP];
        xfilt_n = wr_data_i[B_XFILT];
        xdrv_n  = wr_data_i[B_XDRV_HI:B_XDRV_LO];
      end
      if (wr_data_i[B_SECEN] || sec_clr_ok) secen_n = wr_data_i[B_SECEN];
      if (rtc_open)  rtc_n  = wr_data_i[B_RTC_HI:B_RTC_LO];
      if (idiv_open) idiv_n = wr_data_i[B_IDIV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xen_q <= 1'b0;  xbyp_q <= 1'b0;  xfilt_q <= 1'b0;  xdrv_q <= '0;
      secen_q <= 1'b0;  fail_q <= 1'b0;  sysen_q <= 1'b0;  rtc_q <= '0;
      ien_q <= 1'b0;  idiv_q <= 1'b0;
    end else begin
      xen_q <= xen_n;  xbyp_q <= xbyp_n;  xfilt_q <= xfilt_n;  xdrv_q <= xdrv_n;
      secen_q <= secen_n;  fail_q <= fail_n;  sysen_q <= sysen_n;  rtc_q <= rtc_n;
      ien_q <= ien_n;  idiv_q <= idiv_n;
    end
  end

  lsclk_rdy_track #(.ON_TICKS(XON_TICKS), .OFF_TICKS(XOFF_TICKS)) u_xtrk (
    .clk(clk), .rst_n(rst_n), .clr_i(dom_rst_i), .en_i(xen_q),
    .tick_i(ext_tick_i), .hold_i(1'b0), .rdy_o(xrdy));

  lsclk_rdy_track #(.ON_TICKS(ION_TICKS), .OFF_TICKS(IOFF_TICKS)) u_itrk (
    .clk(clk), .rst_n(rst_n), .clr_i(dom_rst_i), .en_i(ien_q),
    .tick_i(int_tick_i), .hold_i(int_in_use_i), .rdy_o(irdy));

  lsclk_rdy_track #(.ON_TICKS(SYSON_TICKS), .OFF_TICKS(0)) u_strk (
    .clk(clk), .rst_n(rst_n), .clr_i(dom_rst_i), .en_i(sysen_q && xen_q && xrdy),
    .tick_i(ext_tick_i), .hold_i(1'b0), .rdy_o(sysrdy));

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[B_XEN]               = xen_q;
    rd_data_o[B_XRDY]              = xrdy;
    rd_data_o[B_XBYP]              = xbyp_q;
    rd_data_o[B_XDRV_HI:B_XDRV_LO] = xdrv_q;
    rd_data_o[B_SECEN]             = secen_q;
    rd_data_o[B_FAIL]              = fail_q;
    rd_data_o[B_SYSEN]             = sysen_q;
    rd_data_o[B_RTC_HI:B_RTC_LO]   = rtc_q;
    rd_data_o[B_SYSRDY]            = sysrdy;
    rd_data_o[B_XFILT]             = xfilt_q;
    rd_data_o[B_IEN]               = ien_q;
    rd_data_o[B_IRDY]              = irdy;
    rd_data_o[B_IDIV]              = idiv_q;
  end

  logic wr_unused;
  assign wr_unused = ^{wr_data_i[31:27], wr_data_i[23:13], wr_data_i[11:10],
                       wr_data_i[B_FAIL], wr_data_i[B_XRDY], wr_data_i[B_IRDY]};

  a_r1_dom_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst_i |=> ((rd_data_o & ~(32'd1 << B_IRDY)) == '0));
  a_r4_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
    int_in_use_i |-> rd_data_o[B_IRDY]);
  a_r5_xcfg_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ((xen_q || xrdy) && !dom_rst_i) |=> $stable({xbyp_q, xdrv_q, xfilt_q}));
  a_r6_sys_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(xen_q && xrdy) |=> !sysrdy);
  a_r7_sec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (secen_q && !fail_q && !dom_rst_i) |=> secen_q);
  a_r8_fail_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(fail_i));
  a_r9_rtc_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ((rtc_q != '0) && !fail_q && !dom_rst_i) |=> $stable(rtc_q));
  a_r10_div_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_q || irdy || int_in_use_i) && !dom_rst_i) |=> $stable(idiv_q));
endmodule

// File: tb/lsclk_ctrl_reg_test.sv
module lsclk_ctrl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n, dom_rst, wr_en, ext_tick, int_tick, in_use, fail;
  logic [31:0] wr_data, rd_data;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  lsclk_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .dom_rst_i(dom_rst), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .ext_tick_i(ext_tick),
    .int_tick_i(int_tick), .int_in_use_i(in_use), .fail_i(fail));

  // write data / expected readback, applied from reset with all clocks idle
  localparam int NV = 9;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_101C, 32'h0000_101C},  // R5 config open while oscillator off
    {32'h0000_0042, 32'h0000_0000},  // R8 status bits ignore writes
    {32'h0400_0000, 32'h0400_0000},  // R10 divider open
    {32'h0000_0100, 32'h0000_0100},  // R9 first RTC select
    {32'h0000_0200, 32'h0000_0100},  // R9 locked
    {32'h0000_0120, 32'h0000_0120},  // R7 security enable set
    {32'h0000_0100, 32'h0000_0120},  // R7 clear ignored
    {32'h0200_0120, 32'h0000_0120},  // R8 internal ready not writable
    {32'h0000_0920, 32'h0000_0120}   // R8 system ready not writable
  };

  task automatic check(string tag, logic [31:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, rd_data, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic xt(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
    end
  endtask

  task automatic it(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); int_tick = 1'b1;
      @(negedge clk); int_tick = 1'b0;
    end
  endtask

  task automatic dom();
    @(negedge clk); dom_rst = 1'b1;
    @(negedge clk); dom_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; dom_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
    ext_tick = 1'b0; int_tick = 1'b0; in_use = 1'b0; fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 32'h0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][63:32]);
      check($sformatf("table %0d", v), VEC[v][31:0]);
    end
    dom();
    check("R1 domain reset", 32'h0);
    wr(32'h0000_0200);
    check("R9 select free after domain reset", 32'h0000_0200);

    // external oscillator and derived system clock
    dom();
    wr(32'h1);      check("R11 ext enable", 32'h1);
    xt(3);          check("R11 ext not ready at 3", 32'h1);
    xt(1);          check("R11 ext ready at 4", 32'h3);
    wr(32'h101D);   check("R5 config locked while on", 32'h3);
    wr(32'h81);     check("R6 sys enable", 32'h83);
    xt(1);          check("R6 sys not ready at 1", 32'h83);
    xt(1);          check("R6 sys ready at 2", 32'h883);
    wr(32'h80);
    @(negedge clk); check("R6 sys drops with ext enable", 32'h82);
    xt(5);          check("R2 ext ready held at 5", 32'h82);
    wr(32'h84);     check("R5 config locked while ready", 32'h82);
    xt(1);          check("R2 ext ready drops at 6", 32'h80);
    wr(32'h84);     check("R5 config open when off", 32'h84);

    // restart of count on toggle
    wr(32'h1);      xt(3);
    wr(32'h0);      wr(32'h1);
    xt(3);          check("R12 count restarted", 32'h1);
    xt(1);          check("R12 ready after full count", 32'h3);

    // internal oscillator
    dom();
    wr(32'h0100_0000);
    it(1);          check("R11 int not ready at 1", 32'h0100_0000);
    it(1);          check("R11 int ready at 2", 32'h0300_0000);
    wr(32'h0);      it(2);
    check("R3 int ready held at 2", 32'h0200_0000);
    wr(32'h0400_0000); check("R10 divider locked while ready", 32'h0200_0000);
    it(1);          check("R3 int ready drops at 3", 32'h0);
    wr(32'h0400_0000); check("R10 divider open", 32'h0400_0000);
    wr(32'h0);      check("R10 divider cleared", 32'h0);
    in_use = 1'b1;
    @(negedge clk); check("R4 ready forced by user", 32'h0200_0000);
    wr(32'h0400_0000); check("R10 divider locked by user", 32'h0200_0000);
    in_use = 1'b0;
    @(negedge clk); check("R4 ready released", 32'h0);

    // failure path
    dom();
    wr(32'h120);    check("R7 security on", 32'h120);
    wr(32'h200);    check("R9 R7 both locked", 32'h120);
    @(negedge clk); fail = 1'b1;
    @(negedge clk); fail = 1'b0;
    check("R8 failure flag set", 32'h160);
    wr(32'h200);    check("R7 R9 unlocked by failure", 32'h240);
    wr(32'h0);      check("R8 flag survives write", 32'h40);
    dom();          check("R1 domain reset clears flag", 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule